// File: doc/BRIEF.md
# Video Byte-Lane Multiply-Add Unit

This execution unit computes `A × B + C` on 32-bit words, where A and B are each first narrowed to a selected lane of their source. A lane is either one of four bytes or one of two 16-bit halves. Each lane is widened back to 32 bits using that operand's own signedness. Operand B may instead come from a 16-bit immediate, which is sign- or zero-extended. C is always the full 32-bit word.

After the add, an optional fixed right shift by 7 or 15 bits can be applied. The shift is arithmetic when either source is marked signed and logical otherwise. The result and, when requested, zero/negative condition flags are registered once behind a valid strobe. A new operation can be accepted on every cycle.

Two lane-kind encodings are not supported: the full-word kind and the reserved kind. Either one turns the affected operand into zero and raises an error bit that travels with the result.

Top module: `vmad_unit`

## Requirements
- R1: With half mode off, an operand is the byte at bits [8·idx+7 : 8·idx] (idx 0..3), zero-extended when its signed bit is 0 and sign-extended when it is 1.
- R2: With half mode on, lane kind 0 selects bits [15:0] and lane kind 1 selects bits [31:16], extended by the operand's own signed bit.
- R3: With half mode on, lane kind 2 or 3 on a register operand makes that operand zero and sets `out_err` for that result. An immediate B never raises `out_err`, whatever its lane fields hold.
- R4: When `b_from_reg` is 0, B is `b_imm`, sign-extended if `b_signed` is 1 and zero-extended otherwise.
- R5: The pre-shift value is the low 32 bits of A·B + C, with C used in full.
- R6: `shift_ctl` 0 or 3 applies no shift, 1 shifts right by 7 and 2 shifts right by 15. The shift is arithmetic if `a_signed` or `b_signed` is 1, and logical otherwise.
- R7: An accepted operation with `flags_en` = 1 raises `out_flags_we` with its result, and loads `out_zero` (result == 0) and `out_neg` (result bit 31). Otherwise `out_flags_we` is 0 and both flags keep their values.
- R8: `out_valid` and the result for an operation appear exactly one cycle after `in_valid`, back-to-back operations are accepted every cycle, and the result and error outputs hold while `in_valid` is low.
- R9: While reset is asserted, `out_valid`, `out_result`, `out_flags_we`, `out_zero`, `out_neg` and `out_err` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation present this cycle |
| a_word | input | 32 | Operand A source word |
| a_half_mode | input | 1 | A uses a 16-bit half rather than a byte |
| a_half_kind | input | 2 | A half kind: 0 low, 1 high, 2/3 unsupported |
| a_byte_idx | input | 2 | A byte index |
| a_signed | input | 1 | A lane is signed |
| b_from_reg | input | 1 | B taken from `b_word` (1) or `b_imm` (0) |
| b_word | input | 32 | Operand B source word |
| b_imm | input | 16 | Immediate B |
| b_half_mode | input | 1 | B uses a 16-bit half rather than a byte |
| b_half_kind | input | 2 | B half kind, same encoding as A |
| b_byte_idx | input | 2 | B byte index |
| b_signed | input | 1 | B lane or immediate is signed |
| c_word | input | 32 | Full-width addend |
| shift_ctl | input | 2 | Post-shift select |
| flags_en | input | 1 | Update condition flags |
| out_valid | output | 1 | Result valid |
| out_result | output | 32 | Registered result |
| out_flags_we | output | 1 | Flags were updated with this result |
| out_zero | output | 1 | Zero flag |
| out_neg | output | 1 | Negative flag |
| out_err | output | 1 | An unsupported lane kind was used |

## Verification
Every output sits one register away from its inputs. A fault in lane selection, extension or shift therefore shows as a wrong `out_result` on the cycle right after the offending operation. A wrong sign choice only becomes visible once a shifted, negative sum exposes the upper bits, so the stimulus includes such sums under both signed and unsigned settings.

Faults in the flag or data hold paths stay hidden while operations keep arriving. They surface only on the cycle after an idle or flag-disabled beat, which is why the tests insert those beats on purpose.

// File: rtl/vmad_pkg.sv
package vmad_pkg;
  localparam int LANE_IDX_W = 2;

  typedef enum logic [1:0] {
    HK_LOW  = 2'd0,
    HK_HIGH = 2'd1,
    HK_WIDE = 2'd2,
    HK_RSVD = 2'd3
  } half_kind_e;

  typedef enum logic [1:0] {
    SH_OFF   = 2'd0,
    SH_SEVEN = 2'd1,
    SH_FIFTN = 2'd2,
    SH_OFF2  = 2'd3
  } shift_e;

  typedef struct packed {
    logic                  half_mode;
    half_kind_e            kind;
    logic [LANE_IDX_W-1:0] byte_idx;
    logic                  is_signed;
  } lane_sel_t;
endpackage

// File: rtl/vmad_lane_pick.sv
module vmad_lane_pick
  import vmad_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LANE_W = 8,
  parameter int HALF_W = 16
) (
  input  logic [DATA_W-1:0] word,
  input  lane_sel_t         sel,
  output logic [DATA_W-1:0] value,
  output logic              bad
);
  localparam int BYTE_PAD = DATA_W - LANE_W;
  localparam int HALF_PAD = DATA_W - HALF_W;

  logic [LANE_W-1:0] byte_lane;
  logic [HALF_W-1:0] half_lane;

  always_comb begin
    byte_lane = word[sel.byte_idx*LANE_W +: LANE_W];
    half_lane = (sel.kind == HK_HIGH) ? word[HALF_W +: HALF_W] : word[0 +: HALF_W];
    bad       = 1'b0;
    if (!sel.half_mode) begin
      value = {{BYTE_PAD{sel.is_signed & byte_lane[LANE_W-1]}}, byte_lane};
    end else if (sel.kind == HK_LOW || sel.kind == HK_HIGH) begin
      value = {{HALF_PAD{sel.is_signed & half_lane[HALF_W-1]}}, half_lane};
    end else begin
      value = '0;
      bad   = 1'b1;
    end
  end
endmodule

// File: rtl/vmad_mac.sv
module vmad_mac
  import vmad_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int SHIFT_A = 7,
  parameter int SHIFT_B = 15
) (
  input  logic [DATA_W-1:0] op_a,
  input  logic [DATA_W-1:0] op_b,
  input  logic [DATA_W-1:0] op_c,
  input  shift_e            shift_sel,
  input  logic              signed_op,
  output logic [DATA_W-1:0] result
);
  logic [DATA_W-1:0] prod;
  logic [DATA_W-1:0] sum;
  logic [DATA_W-1:0] shr_a;
  logic [DATA_W-1:0] shr_b;

  always_comb begin
    prod = op_a * op_b;
    sum  = prod + op_c;
    if (signed_op) begin
      shr_a = DATA_W'($signed(sum) >>> SHIFT_A);
      shr_b = DATA_W'($signed(sum) >>> SHIFT_B);
    end else begin
      shr_a = sum >> SHIFT_A;
      shr_b = sum >> SHIFT_B;
    end
    unique case (shift_sel)
      SH_SEVEN: result = shr_a;
      SH_FIFTN: result = shr_b;
      default:  result = sum;
    endcase
  end
endmodule

// File: rtl/vmad_unit.sv
module vmad_unit
  import vmad_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int IMM_W   = 16,
  parameter int LANE_W  = 8,
  parameter int SHIFT_A = 7,
  parameter int SHIFT_B = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] a_word,
  input  logic              a_half_mode,
  input  logic [1:0]        a_half_kind,
  input  logic [1:0]        a_byte_idx,
  input  logic              a_signed,
  input  logic              b_from_reg,
  input  logic [DATA_W-1:0] b_word,
  input  logic [IMM_W-1:0]  b_imm,
  input  logic              b_half_mode,
  input  logic [1:0]        b_half_kind,
  input  logic [1:0]        b_byte_idx,
  input  logic              b_signed,
  input  logic [DATA_W-1:0] c_word,
  input  logic [1:0]        shift_ctl,
  input  logic              flags_en,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_result,
  output logic              out_flags_we,
  output logic              out_zero,
  output logic              out_neg,
  output logic              out_err
);
  localparam int N_SRC  = 2;
  localparam int HALF_W = DATA_W / 2;
  localparam int IMM_PAD = DATA_W - IMM_W;

  logic [DATA_W-1:0] src_word [N_SRC];
  lane_sel_t         src_sel  [N_SRC];
  logic [DATA_W-1:0] src_val  [N_SRC];
  logic              src_bad  [N_SRC];

  always_comb begin
    src_word[0] = a_word;
    src_word[1] = b_word;
    src_sel[0]  = '{half_mode: a_half_mode, kind: half_kind_e'(a_half_kind),
                    byte_idx: a_byte_idx, is_signed: a_signed};
    src_sel[1]  = '{half_mode: b_half_mode, kind: half_kind_e'(b_half_kind),
                    byte_idx: b_byte_idx, is_signed: b_signed};
  end

  for (genvar g = 0; g < N_SRC; g++) begin : g_pick
    vmad_lane_pick #(.DATA_W(DATA_W), .LANE_W(LANE_W), .HALF_W(HALF_W)) pick_i (
      .word  (src_word[g]),
      .sel   (src_sel[g]),
      .value (src_val[g]),
      .bad   (src_bad[g])
    );
  end

  logic [DATA_W-1:0] b_operand;
  logic              err_d;
  logic [DATA_W-1:0] mac_res;

  always_comb begin
    if (b_from_reg) begin
      b_operand = src_val[1];
    end else begin
      b_operand = {{IMM_PAD{b_signed & b_imm[IMM_W-1]}}, b_imm};
    end
    err_d = src_bad[0] | (b_from_reg & src_bad[1]);
  end

  vmad_mac #(.DATA_W(DATA_W), .SHIFT_A(SHIFT_A), .SHIFT_B(SHIFT_B)) mac_i (
    .op_a      (src_val[0]),
    .op_b      (b_operand),
    .op_c      (c_word),
    .shift_sel (shift_e'(shift_ctl)),
    .signed_op (a_signed | b_signed),
    .result    (mac_res)
  );

  // next-state logic
  logic              data_en;
  logic              flag_en;
  logic              valid_d;
  logic              fwe_d;
  logic [DATA_W-1:0] res_d;
  logic              errq_d;
  logic              zero_d;
  logic              neg_d;

  always_comb begin
    data_en = in_valid;
    flag_en = in_valid & flags_en;
    valid_d = in_valid;
    fwe_d   = flag_en;
    res_d   = data_en ? mac_res : out_result;
    errq_d  = data_en ? err_d : out_err;
    zero_d  = flag_en ? (mac_res == '0) : out_zero;
    neg_d   = flag_en ? mac_res[DATA_W-1] : out_neg;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid    <= 1'b0;
      out_flags_we <= 1'b0;
      out_result   <= '0;
      out_err      <= 1'b0;
      out_zero     <= 1'b0;
      out_neg      <= 1'b0;
    end else begin
      out_valid    <= valid_d;
      out_flags_we <= fwe_d;
      out_result   <= res_d;
      out_err      <= errq_d;
      out_zero     <= zero_d;
      out_neg      <= neg_d;
    end
  end
endmodule

// File: rtl/vmad_unit_chk.sv
module vmad_unit_chk #(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              a_half_mode,
  input logic [1:0]        a_half_kind,
  input logic              flags_en,
  input logic              out_valid,
  input logic [DATA_W-1:0] out_result,
  input logic              out_flags_we,
  input logic              out_zero,
  input logic              out_neg,
  input logic              out_err
);
  // R8
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  // R8
  valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  // R8
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(out_result) && $stable(out_err)));
  // R7
  flag_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && flags_en) |=> out_flags_we);
  // R7
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && flags_en) |=> (!out_flags_we && $stable(out_zero) && $stable(out_neg)));
  // R7
  flag_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_flags_we |-> ((out_zero == (out_result == '0)) && (out_neg == out_result[DATA_W-1])));
  // R3
  bad_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && a_half_mode && a_half_kind[1]) |=> out_err);
  // R9
  always @(posedge clk) begin
    if (!rst_n) begin
      reset_clear_chk: assert (!out_valid && !out_flags_we && !out_err && out_result == '0);
    end
  end
endmodule

bind vmad_unit vmad_unit_chk #(.DATA_W(DATA_W), .IMM_W(IMM_W)) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .in_valid     (in_valid),
  .a_half_mode  (a_half_mode),
  .a_half_kind  (a_half_kind),
  .flags_en     (flags_en),
  .out_valid    (out_valid),
  .out_result   (out_result),
  .out_flags_we (out_flags_we),
  .out_zero     (out_zero),
  .out_neg      (out_neg),
  .out_err      (out_err)
);

// File: tb/vmad_unit_test.sv
module vmad_unit_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [31:0] a_word, b_word, c_word;
  logic        a_half_mode, a_signed, b_from_reg, b_half_mode, b_signed, flags_en;
  logic [1:0]  a_half_kind, a_byte_idx, b_half_kind, b_byte_idx, shift_ctl;
  logic [15:0] b_imm;
  logic        out_valid, out_flags_we, out_zero, out_neg, out_err;
  logic [31:0] out_result;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  logic [31:0] exp_res;
  logic        exp_err;
  logic        exp_z = 1'b0;
  logic        exp_n = 1'b0;

  always #2.5 clk = ~clk;

  vmad_unit uut (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] lane_of(input logic [31:0] w, input logic hm, input logic [1:0] k,
                                          input logic [1:0] idx, input logic s, output logic bad);
    int v;
    bad = 1'b0;
    if (!hm) begin
      v = int'((w >> (8 * idx)) & 32'hFF);
      if (s && v >= 128) v = v - 256;
    end else if (k == 2'd0 || k == 2'd1) begin
      v = int'((w >> (16 * k)) & 32'hFFFF);
      if (s && v >= 32768) v = v - 65536;
    end else begin
      v = 0;
      bad = 1'b1;
    end
    return 32'(v);
  endfunction

  // computes expected outputs for the current input set
  task automatic model();
    logic [31:0] av, bv, s;
    logic ba, bb;
    av = lane_of(a_word, a_half_mode, a_half_kind, a_byte_idx, a_signed, ba);
    if (b_from_reg) bv = lane_of(b_word, b_half_mode, b_half_kind, b_byte_idx, b_signed, bb);
    else begin
      bb = 1'b0;
      bv = (b_signed && b_imm[15]) ? (32'hFFFF0000 | 32'(b_imm)) : 32'(b_imm);
    end
    s = av * bv + c_word;
    if (shift_ctl == 2'd1 || shift_ctl == 2'd2) begin
      if (a_signed || b_signed) s = 32'($signed(s) >>> ((shift_ctl == 2'd1) ? 7 : 15));
      else s = s >> ((shift_ctl == 2'd1) ? 7 : 15);
    end
    exp_res = s;
    exp_err = ba | bb;
    if (flags_en) begin
      exp_z = (s == 32'd0);
      exp_n = s[31];
    end
  endtask

  task automatic set_a(input logic [31:0] w, input logic hm, input logic [1:0] k, input logic [1:0] i, input logic s);
    a_word = w; a_half_mode = hm; a_half_kind = k; a_byte_idx = i; a_signed = s;
  endtask

  task automatic set_b(input logic fr, input logic [31:0] w, input logic [15:0] imm, input logic hm,
                       input logic [1:0] k, input logic [1:0] i, input logic s);
    b_from_reg = fr; b_word = w; b_imm = imm; b_half_mode = hm; b_half_kind = k; b_byte_idx = i; b_signed = s;
  endtask

  // issue one operation at a negedge, check at the next negedge
  task automatic one_op(input string req, input logic [31:0] c, input logic [1:0] sh, input logic fe);
    c_word = c; shift_ctl = sh; flags_en = fe; in_valid = 1'b1;
    model();
    @(negedge clk);
    in_valid = 1'b0;
    check(req, out_result, exp_res);
    check(req, 32'(out_err), 32'(exp_err));
    check(req, 32'(out_valid), 32'd1);
  endtask

  task automatic t_reset();
    check("R9", 32'(out_valid), 32'd0);
    check("R9", out_result, 32'd0);
    check("R9", {29'd0, out_flags_we, out_zero, out_neg}, 32'd0);
    check("R9", 32'(out_err), 32'd0);
  endtask

  task automatic t_bytes();
    for (int i = 0; i < 4; i++) begin
      set_a(32'h80FF7F01, 1'b0, 2'd0, 2'(i), 1'b0);
      set_b(1'b1, 32'h00000300, 16'h0, 1'b0, 2'd0, 2'd1, 1'b0);
      one_op("R1", 32'd5, 2'd0, 1'b0);
      set_a(32'h80FF7F01, 1'b0, 2'd0, 2'(i), 1'b1);
      one_op("R1", 32'd5, 2'd0, 1'b0);
    end
    // hard value: byte 3 signed (0x80 = -128) * 3 + 5 = -379
    set_a(32'h80000000, 1'b0, 2'd0, 2'd3, 1'b1);
    one_op("R1", 32'd5, 2'd0, 1'b0);
    check("R1", out_result, 32'hFFFFFE85);
  endtask

  task automatic t_halves();
    set_a(32'hC0011234, 1'b1, 2'd0, 2'd0, 1'b0);
    set_b(1'b1, 32'hFFFE0002, 16'h0, 1'b1, 2'd1, 2'd0, 1'b1);
    one_op("R2", 32'd0, 2'd0, 1'b0);
    check("R2", out_result, 32'hFFFFDB98); // 0x1234 * -2
    set_a(32'hC0011234, 1'b1, 2'd1, 2'd0, 1'b1);
    set_b(1'b1, 32'hFFFE0002, 16'h0, 1'b1, 2'd0, 2'd0, 1'b0);
    one_op("R2", 32'd1, 2'd0, 1'b0);
    check("R2", out_result, 32'hFFFF8003); // 0xC001 signed * 2 + 1
  endtask

  task automatic t_bad_kind();
    set_a(32'h12345678, 1'b1, 2'd2, 2'd0, 1'b0);
    set_b(1'b1, 32'h7, 16'h0, 1'b0, 2'd0, 2'd0, 1'b0);
    one_op("R3", 32'h0000ABCD, 2'd0, 1'b0);
    check("R3", out_result, 32'h0000ABCD);
    check("R3", 32'(out_err), 32'd1);
    set_a(32'h4, 1'b0, 2'd0, 2'd0, 1'b0);
    set_b(1'b1, 32'h7, 16'h0, 1'b1, 2'd3, 2'd0, 1'b0);
    one_op("R3", 32'd1, 2'd0, 1'b0);
    check("R3", out_result, 32'd1);
    set_b(1'b0, 32'h7, 16'h0002, 1'b1, 2'd3, 2'd0, 1'b0);
    one_op("R3", 32'd1, 2'd0, 1'b0);
    check("R3", 32'(out_err), 32'd0);
    check("R3", out_result, 32'd9);
  endtask

  task automatic t_imm();
    set_a(32'h3, 1'b0, 2'd0, 2'd0, 1'b0);
    set_b(1'b0, 32'h0, 16'hFFFF, 1'b0, 2'd0, 2'd0, 1'b1);
    one_op("R4", 32'd10, 2'd0, 1'b0);
    check("R4", out_result, 32'd7);
    set_b(1'b0, 32'h0, 16'hFFFF, 1'b0, 2'd0, 2'd0, 1'b0);
    one_op("R4", 32'd10, 2'd0, 1'b0);
    check("R4", out_result, 32'h00030007);
  endtask

  task automatic t_mac();
    set_a(32'hFFFF0000, 1'b1, 2'd1, 2'd0, 1'b0);
    set_b(1'b1, 32'h0000FFFF, 16'h0, 1'b1, 2'd0, 2'd0, 1'b0);
    one_op("R5", 32'h80000000, 2'd0, 1'b0);
    check("R5", out_result, 32'h7FFE0001); // 0xFFFE0001 + 0x80000000 wraps
  endtask

  task automatic t_shift();
    // sum = -1 * 256 + 0 = 0xFFFFFF00
    set_a(32'h000000FF, 1'b0, 2'd0, 2'd0, 1'b1);
    set_b(1'b0, 32'h0, 16'h0100, 1'b0, 2'd0, 2'd0, 1'b0);
    one_op("R6", 32'd0, 2'd1, 1'b0);
    check("R6", out_result, 32'hFFFFFFFE);
    one_op("R6", 32'd0, 2'd2, 1'b0);
    check("R6", out_result, 32'hFFFFFFFF);
    one_op("R6", 32'd0, 2'd3, 1'b0);
    check("R6", out_result, 32'hFFFFFF00);
    // unsigned: 255 * 256 + 0x80000000, logical
    set_a(32'h000000FF, 1'b0, 2'd0, 2'd0, 1'b0);
    one_op("R6", 32'h80000000, 2'd1, 1'b0);
    check("R6", out_result, 32'h010001FE);
    one_op("R6", 32'h80000000, 2'd2, 1'b0);
    check("R6", out_result, 32'h00010001);
  endtask

  task automatic t_flags();
    set_a(32'h0, 1'b0, 2'd0, 2'd0, 1'b0);
    set_b(1'b0, 32'h0, 16'h5, 1'b0, 2'd0, 2'd0, 1'b0);
    one_op("R7", 32'd0, 2'd0, 1'b1);
    check("R7", {30'd0, out_zero, out_neg}, 32'h2);
    check("R7", 32'(out_flags_we), 32'd1);
    one_op("R7", 32'hF0000000, 2'd0, 1'b0);
    check("R7", 32'(out_flags_we), 32'd0);
    check("R7", {30'd0, out_zero, out_neg}, {30'd0, exp_z, exp_n});
    check("R7", {30'd0, out_zero, out_neg}, 32'h2);
    one_op("R7", 32'hF0000000, 2'd0, 1'b1);
    check("R7", {30'd0, out_zero, out_neg}, 32'h1);
  endtask

  task automatic t_pipe();
    logic [31:0] e0;
    set_a(32'h00000009, 1'b0, 2'd0, 2'd0, 1'b0);
    set_b(1'b0, 32'h0, 16'h0003, 1'b0, 2'd0, 2'd0, 1'b0);
    c_word = 32'd1; shift_ctl = 2'd0; flags_en = 1'b0; in_valid = 1'b1;
    model(); e0 = exp_res;
    @(negedge clk);
    check("R8", out_result, e0);
    c_word = 32'd100; model(); e0 = exp_res;
    @(negedge clk);
    check("R8", out_result, e0);
    check("R8", 32'(out_valid), 32'd1);
    in_valid = 1'b0;
    c_word = 32'd7;
    @(negedge clk);
    check("R8", 32'(out_valid), 32'd0);
    check("R8", out_result, e0);
    @(negedge clk);
    check("R8", out_result, e0);
  endtask

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; flags_en = 1'b0; shift_ctl = 2'd0; c_word = '0;
    set_a(32'h0, 1'b0, 2'd0, 2'd0, 1'b0);
    set_b(1'b0, 32'h0, 16'h0, 1'b0, 2'd0, 2'd0, 1'b0);
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_bytes();
    t_halves();
    t_bad_kind();
    t_imm();
    t_mac();
    t_shift();
    t_flags();
    t_pipe();
    done = 1'b1;
  end

  initial begin
    for (int i = 0; i < 20000 && !done; i++) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
    end
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule